// File: doc/BRIEF.md
# Supply Monitor Mode Controller

This block holds the supervisory decisions of a battery-backed supply monitor. It receives the digital outputs of three analog comparators and one sleep-control pin, none of them synchronous to its clock. These are: the divided main rail is above its reference, the main rail is above the battery, and the battery is above its own threshold. From the sleep pin and the main-versus-battery flag it decodes one of four operating modes. It then chooses which comparator flag guards the reset. A dropout on the guarded flag has to last a programmable number of clock ticks before it counts. When the flag comes back, a power-on delay runs before the reset request is released.

The outputs go to the rest of the supervisor. The first is an active-low reset request. The second is an enable that lets a separate watchdog core accept clear pulses. The third is an active-low power-fail flag that shows when the main rail is not above the battery. The decoded mode is also brought out so that the neighbouring logic can follow it. Any change of mode restarts the power-on delay, so the reset request never releases straight into a mode that has not settled.

Top module: `supmon_mode_ctrl`

## Requirements
- R1: With the sleep pin low and main above battery, the mode output reads 0 (main-rail supervision), and the guarded flag is the main-rail comparator.
- R2: With the sleep pin low and main not above battery, the mode output reads 1 (sleep).
- R3: With the sleep pin high and main above battery, the mode output reads 2 (watchdog supervision). The watchdog enable is high only in this mode, and only while the reset request is released.
- R4: With the sleep pin high and main not above battery, the mode output reads 3 (battery supervision).
- R5: In sleep mode the reset request is held high (released) and the watchdog enable is low, so clear pulses are ignored, whatever the comparator flags do.
- R6: In battery supervision the guarded flag is the battery-threshold comparator. The main-rail comparator then has no effect on the reset request.
- R7: The power-fail output is low whenever main is not above battery, in every mode.
- R8: A guarded flag that stays low for SENS_TICKS consecutive synchronised cycles asserts the reset request (low) on the following cycle. A dropout shorter than SENS_TICKS leaves the reset request high.
- R9: Once the guarded flag returns high after a qualified dropout, the reset request stays low for POR_TICKS further cycles. It releases on the cycle after the count completes, which is POR_TICKS+4 clock edges after the flag rises at the pin.
- R10: A change of the decoded mode into any mode other than sleep drives the reset request low on the next edge and restarts the power-on delay. The request releases POR_TICKS+4 edges after the causing pin change.
- R11: Every comparator and sleep input passes through two flip-flops. A pin change appears on the mode output after two clock edges and on the power-fail output after three.
- R12: While the reset input is low, the reset request, the watchdog enable and the power-fail output are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_hi_a | input | 1 | Main-rail divider above reference (asynchronous) |
| main_hi_a | input | 1 | Main rail above battery (asynchronous) |
| bat_hi_a | input | 1 | Battery above its threshold (asynchronous) |
| sleep_pin_a | input | 1 | Sleep-control pin (asynchronous) |
| rst_req_n | output | 1 | Active-low reset request |
| wd_en | output | 1 | Allows the watchdog core to accept clear pulses |
| pfail_n | output | 1 | Active-low power-fail flag |
| mode_o | output | 2 | Decoded mode: 0 main, 1 sleep, 2 watchdog, 3 battery |

## Verification
A mode change and a qualifying dropout can both reload the power-on counter in the same stretch of cycles. The bench provokes this by lowering the main-rail flag on the same clock as the sleep pin that moves the block from watchdog to main supervision. The expected result is that the mode change alone pulls the reset request low three edges later. The request then stays low through the whole dropout, and release is timed only from the flag's recovery, not from the earlier mode change. A second overlap happens when sleep is entered: the mode change and the power-fail assertion land on the same edge, and the reset request must stay released there.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

  typedef enum logic [1:0] {
    MD_MAIN  = 2'd0,
    MD_SLEEP = 2'd1,
    MD_WDOG  = 2'd2,
    MD_BATT  = 2'd3
  } md_e;

  // Four-way decode of the sleep pin and the main-versus-battery flag.
  function automatic md_e pick_mode(input logic sleep_pin, input logic main_hi);
    md_e m;
    case ({sleep_pin, main_hi})
      2'b01:   m = MD_MAIN;
      2'b00:   m = MD_SLEEP;
      2'b11:   m = MD_WDOG;
      default: m = MD_BATT;
    endcase
    return m;
  endfunction

  // Which comparator guards the reset in a given mode.
  function automatic logic guarded_flag(input md_e m, input logic vin_hi, input logic bat_hi);
    return (m == MD_BATT) ? bat_hi : vin_hi;
  endfunction

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/supmon_filter.sv
module supmon_filter #(
  parameter int unsigned SENS_TICKS = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_ok,
  output logic dropped
);
  localparam int unsigned CW = $clog2(SENS_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(SENS_TICKS);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (flag_ok)        low_cnt <= '0;
    else if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
  end

  assign dropped = (low_cnt == LIM);
endmodule

// File: rtl/supmon_por.sv
module supmon_por #(
  parameter int unsigned POR_TICKS = 20000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);
  localparam int unsigned CW = $clog2(POR_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(POR_TICKS);

  logic [CW-1:0] por_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              por_cnt <= '0;
    else if (restart)        por_cnt <= '0;
    else if (por_cnt != LIM) por_cnt <= por_cnt + 1'b1;
  end

  assign done = (por_cnt == LIM);
endmodule

// File: rtl/supmon_mode_ctrl.sv
module supmon_mode_ctrl
  import supmon_pkg::*;
#(
  parameter int unsigned SENS_TICKS = 1250,
  parameter int unsigned POR_TICKS  = 20000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vin_hi_a,
  input  logic       main_hi_a,
  input  logic       bat_hi_a,
  input  logic       sleep_pin_a,
  output logic       rst_req_n,
  output logic       wd_en,
  output logic       pfail_n,
  output logic [1:0] mode_o
);
  localparam int unsigned NIN = 4;

  logic [NIN-1:0] raw_in, sync_in;
  logic s_vin, s_main, s_bat, s_sleep;

  assign raw_in = {sleep_pin_a, bat_hi_a, main_hi_a, vin_hi_a};

  supmon_sync #(.W(NIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_in)
  );

  assign {s_sleep, s_bat, s_main, s_vin} = sync_in;

  // Named internal events, brought out for the checker.
  md_e  mode, mode_q;
  logic mode_chg;
  logic mon_ok;
  logic dropped;
  logic por_done;
  logic released;

  assign mode     = pick_mode(s_sleep, s_main);
  assign mode_chg = (mode != mode_q);
  assign mon_ok   = guarded_flag(mode, s_vin, s_bat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_SLEEP;
    else        mode_q <= mode;
  end

  supmon_filter #(.SENS_TICKS(SENS_TICKS)) u_filter (
    .clk(clk), .rst_n(rst_n), .flag_ok(mon_ok), .dropped(dropped)
  );

  supmon_por #(.POR_TICKS(POR_TICKS)) u_por (
    .clk(clk), .rst_n(rst_n), .restart(dropped | mode_chg), .done(por_done)
  );

  assign released = por_done && !dropped && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_n <= 1'b0;
      wd_en     <= 1'b0;
      pfail_n   <= 1'b0;
    end else begin
      rst_req_n <= (mode == MD_SLEEP) ? 1'b1 : released;
      wd_en     <= (mode == MD_WDOG) && released;
      pfail_n   <= s_main;
    end
  end

  assign mode_o = mode;
endmodule

// File: rtl/supmon_chk.sv
module supmon_chk
  import supmon_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       mode_chg,
  input logic       dropped,
  input logic       s_main,
  input logic       rst_req_n,
  input logic       wd_en,
  input logic       pfail_n
);
  AST_SLEEP_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SLEEP) |=> (rst_req_n && !wd_en)); // R5

  AST_PFAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !s_main |=> !pfail_n); // R7

  AST_DROP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (dropped && mode != MD_SLEEP) |=> !rst_req_n); // R8

  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && mode != MD_SLEEP) |=> !rst_req_n); // R10

  AST_WD_ONLY_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_WDOG) |=> !wd_en); // R3

  AST_WD_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_en |-> rst_req_n); // R3
endmodule

bind supmon_mode_ctrl supmon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .mode_chg(mode_chg),
  .dropped(dropped), .s_main(s_main), .rst_req_n(rst_req_n),
  .wd_en(wd_en), .pfail_n(pfail_n)
);

// File: tb/sim_supmon_mode_ctrl.sv
module sim_supmon_mode_ctrl;
  localparam int unsigned SENS = 4;
  localparam int unsigned POR  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vin = 1'b1, mainh = 1'b1, bat = 1'b1, slp = 1'b0;
  logic rq_n, wde, pf_n;
  logic [1:0] md;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  supmon_mode_ctrl #(.SENS_TICKS(SENS), .POR_TICKS(POR)) u0 (
    .clk(clk), .rst_n(rst_n), .vin_hi_a(vin), .main_hi_a(mainh),
    .bat_hi_a(bat), .sleep_pin_a(slp), .rst_req_n(rq_n), .wd_en(wde),
    .pfail_n(pf_n), .mode_o(md)
  );

  typedef struct {
    logic       r;
    logic       w;
    logic       p;
    logic [1:0] m;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // Driver side: queue the expected output state for this sample point.
  task automatic expect_o(input logic r, input logic w, input logic p,
                          input logic [1:0] m, input string tag);
    exp_t e;
    e.r = r; e.w = w; e.p = p; e.m = m; e.tag = tag;
    sb.push_back(e);
  endtask

  // Wait n rising edges, then land on the following falling edge.
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Monitor side: compare queued expectations with the outputs.
  always @(negedge clk) begin
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (rq_n !== e.r || wde !== e.w || pf_n !== e.p || md !== e.m) begin
        n_fail++;
        $display("FAIL %s: got rst=%b wd=%b pf=%b mode=%0d, want rst=%b wd=%b pf=%b mode=%0d",
                 e.tag, rq_n, wde, pf_n, md, e.r, e.w, e.p, e.m);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_o(0, 0, 0, 2'd1, "R12 outputs during reset");
    rst_n = 1'b1;
    tick(40);
    expect_o(1, 0, 1, 2'd0, "R1 main supervision after power-up");

    // Watchdog mode entry: latency, restart, release
    slp = 1'b1;
    tick(2);
    expect_o(1, 0, 1, 2'd2, "R11 mode after two edges");
    tick(1);
    expect_o(0, 0, 1, 2'd2, "R10 mode change pulls reset");
    tick(20);
    expect_o(0, 0, 1, 2'd2, "R10 still in power-on delay");
    tick(1);
    expect_o(1, 1, 1, 2'd2, "R3 watchdog enabled after release");

    // Short glitch
    vin = 1'b0;
    tick(3);
    vin = 1'b1;
    tick(12);
    expect_o(1, 1, 1, 2'd2, "R8 short dropout ignored");

    // Sustained dropout and recovery
    vin = 1'b0;
    tick(6);
    expect_o(1, 1, 1, 2'd2, "R8 dropout not yet qualified");
    tick(1);
    expect_o(0, 0, 1, 2'd2, "R8 qualified dropout");
    tick(23);
    vin = 1'b1;
    tick(23);
    expect_o(0, 0, 1, 2'd2, "R9 power-on delay running");
    tick(1);
    expect_o(1, 1, 1, 2'd2, "R9 released after delay");

    // Sleep mode
    slp = 1'b0; mainh = 1'b0;
    tick(2);
    expect_o(1, 1, 1, 2'd1, "R2 sleep decode");
    tick(1);
    expect_o(1, 0, 0, 2'd1, "R5 R7 sleep outputs and power-fail");
    vin = 1'b0;
    tick(20);
    expect_o(1, 0, 0, 2'd1, "R5 dropout ignored in sleep");
    vin = 1'b1;
    tick(5);

    // Battery supervision
    slp = 1'b1;
    tick(3);
    expect_o(0, 0, 0, 2'd3, "R4 battery decode with restart");
    tick(20);
    expect_o(0, 0, 0, 2'd3, "R4 delay running");
    tick(1);
    expect_o(1, 0, 0, 2'd3, "R4 battery mode released");
    vin = 1'b0;
    tick(20);
    expect_o(1, 0, 0, 2'd3, "R6 main-rail flag ignored");
    vin = 1'b1;
    tick(2);
    bat = 1'b0;
    tick(6);
    expect_o(1, 0, 0, 2'd3, "R6 battery dropout not yet qualified");
    tick(1);
    expect_o(0, 0, 0, 2'd3, "R6 battery dropout resets");
    tick(9);
    bat = 1'b1;
    tick(23);
    expect_o(0, 0, 0, 2'd3, "R9 battery recovery delay");
    tick(1);
    expect_o(1, 0, 0, 2'd3, "R9 battery recovery released");

    // Back to main supervision
    slp = 1'b0; mainh = 1'b1;
    tick(2);
    expect_o(1, 0, 0, 2'd0, "R11 power-fail lags mode");
    tick(1);
    expect_o(0, 0, 1, 2'd0, "R7 power-fail cleared and R10 restart");
    tick(21);
    expect_o(1, 0, 1, 2'd0, "R1 main mode released");

    // Coincidence: mode change and dropout together
    slp = 1'b1;
    tick(30);
    expect_o(1, 1, 1, 2'd2, "R3 watchdog before overlap");
    vin = 1'b0; slp = 1'b0;
    tick(3);
    expect_o(0, 0, 1, 2'd0, "R10 overlap mode change resets");
    tick(27);
    expect_o(0, 0, 1, 2'd0, "R8 overlap held by dropout");
    vin = 1'b1;
    tick(23);
    expect_o(0, 0, 1, 2'd0, "R9 overlap delay from recovery");
    tick(1);
    expect_o(1, 0, 1, 2'd0, "R9 overlap released");

    tick(2);
    #2;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule